// File: doc/BRIEF.md
# Word-Parallel Bit-Error-Test Pattern Generator

The block produces a bit-error-test stimulus as a 16-bit word on every cycle of a word clock, which runs at one sixteenth of the serial bit rate. A serializer downstream sends bit 0 of each word first. The block has two sources. One is a pseudo-random binary sequence with seven selectable register orders. Sixteen steps of that sequence are computed in a single cycle. The other plays back a user-written pattern of 16 to 256 bits, with the length set in single-bit steps. When the length is not a multiple of 16, a word that crosses the pattern end takes its remaining bits from the start of the pattern, so the serial stream repeats without a seam.

A companion 16-bit trigger word runs alongside the data and is serialized the same way. It can give a square wave at the word rate, a square wave at a quarter of the word rate, or a marker on each repetition of the pattern. A single-cycle error-insertion input flips one bit of a data word, so that a detector can be checked. Mode, order, length and trigger selection are captured only on a synchronous restart. Pattern storage can be written at any time.

Top module: `tpg_top`

## Requirements
- R1: While rst_n is low at a clock edge, data_word and trig_word become 0. The configuration after reset is sequence mode, order code 0, pattern length 16 and trigger code 0. The first sequence word appears at the first edge after rst_n returns high.
- R2: In sequence mode, serial bit n is b[n-p] XOR b[n-q], where every b with a negative index is 1. Bit 16k+i of the stream is bit i of word k. Order code c maps to (p,q) as follows: 0→(7,6), 1→(9,5), 2→(10,7), 3→(11,9), 4→(15,14), 5→(23,18), 6→(31,28). Code 7 acts as code 0.
- R3: For order codes 4, 5 and 6 every sequence bit is driven inverted.
- R4: The sequence repeats with period 2^p−1 bits and never reaches an all-zero register state.
- R5: In pattern mode with length L, bit i of word k is stored bit (16k+i) mod L. A write with wr_en high at an edge stores wr_data into stored bits 16·wr_addr to 16·wr_addr+15, with wr_data bit 0 at the lowest index.
- R6: A pat_len below 16 is taken as 16, and one above 256 is taken as 256.
- R7: The mode and selection inputs are captured only at an edge where restart is high. That edge drives both outputs to 0, and word 0 follows at the next edge. Changing the inputs without a restart has no effect on the outputs.
- R8: Trigger code 0 gives 16'h00FF on every word. Code 1 gives 16'hFFFF on words 0 and 1 and 16'h0000 on words 2 and 3 of every group of four, counting from the restart. Code 3 holds the trigger at 0.
- R9: Trigger code 2 gives 16'hFFFF on each word that contains a stream bit whose index is a multiple of the period (L in pattern mode, 2^p−1 in sequence mode), and 16'h0000 on every other word.
- R10: err_ins high at an edge inverts bit 0 of the data word produced at that edge only. The sequence that follows is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Captures the configuration and restarts the sequence |
| prog_mode | input | 1 | 1 selects pattern playback, 0 selects the pseudo-random sequence |
| prbs_code | input | 3 | Sequence order code |
| pat_len | input | 9 | Pattern length in bits |
| trig_code | input | 2 | Trigger source select |
| err_ins | input | 1 | Flips bit 0 of the word produced at this edge |
| wr_en | input | 1 | Pattern store write strobe |
| wr_addr | input | 4 | Pattern store row (16 bits per row) |
| wr_data | input | 16 | Pattern store row data |
| data_word | output | 16 | Test data word, bit 0 serialized first |
| trig_word | output | 16 | Trigger word, serialized with the data |

## Verification
Every output is registered once. A restart or reset edge therefore clears the outputs one edge after the control is seen, and word k of a run appears k+2 edges after the edge at which restart was driven. The bench drives and samples on falling edges. It checks the word produced by the preceding rising edge and only then changes the inputs for the next one. err_ins and cfg changes without a restart are applied right after one word is checked, so their effect, or lack of effect, shows on the very next sampled word. Pattern writes are completed before the restart of the runs that read them.

// File: rtl/tpg_pkg.sv
// Shared types and order tables for the word-parallel test pattern generator.
package tpg_pkg;

    localparam int HIST_W = 31;   // longest supported register order

    typedef enum logic [1:0] {
        TRIG_WORD = 2'd0,
        TRIG_QUAD = 2'd1,
        TRIG_PAT  = 2'd2,
        TRIG_OFF  = 2'd3
    } trig_mode_e;

    // Index (order minus one) of the oldest history bit fed back.
    function automatic logic [4:0] prbs_hi_idx(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd8;
            3'd2:    return 5'd9;
            3'd3:    return 5'd10;
            3'd4:    return 5'd14;
            3'd5:    return 5'd22;
            3'd6:    return 5'd30;
            default: return 5'd6;
        endcase
    endfunction

    // Index of the inner feedback tap.
    function automatic logic [4:0] prbs_lo_idx(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd4;
            3'd2:    return 5'd6;
            3'd3:    return 5'd8;
            3'd4:    return 5'd13;
            3'd5:    return 5'd17;
            3'd6:    return 5'd27;
            default: return 5'd5;
        endcase
    endfunction

    // Longer orders are emitted inverted.
    function automatic logic prbs_inv(input logic [2:0] code);
        return (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
    endfunction

endpackage

// File: rtl/tpg_prbs_core.sv
// Pseudo-random sequence core: advances a 31-bit history by WORD_W steps per
// cycle with a run-time selected two-tap recurrence.
// Assumes: restart and reset both reload the all-ones seed; the order code is
// held stable between restarts by the caller.
module tpg_prbs_core
    import tpg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [2:0]        code,
    output logic [WORD_W-1:0] word
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;
    logic [HIST_W-1:0] live_mask;
    logic [4:0]        hi_idx;
    logic [4:0]        lo_idx;
    logic              inv;
    logic              nb;

    // Unrolls WORD_W recurrence steps; the newest bit enters at position 0.
    always_comb begin
        hi_idx    = prbs_hi_idx(code);
        lo_idx    = prbs_lo_idx(code);
        inv       = prbs_inv(code);
        live_mask = HIST_W'((32'd1 << (6'(hi_idx) + 6'd1)) - 32'd1);
        hist_d    = hist_q;
        nb        = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            nb      = hist_d[hi_idx] ^ hist_d[lo_idx];
            hist_d  = {hist_d[HIST_W-2:0], nb};
            word[i] = nb ^ inv;
        end
    end

    // Holds the history; reset and restart load the nonzero seed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) hist_q <= '1;
        else                   hist_q <= hist_d;
    end

    // R4
    hist_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q & live_mask) != '0);

endmodule

// File: rtl/tpg_pos.sv
// Stream position tracker: bit index of the next word modulo the period,
// a flag for words holding a period start, and a 2-bit word counter.
// Assumes: period >= WORD_W and period < 2^POS_W - WORD_W.
module tpg_pos #(
    parameter int WORD_W = 16,
    parameter int POS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [POS_W-1:0] period,
    output logic [POS_W-1:0] pos,
    output logic             at_start,
    output logic [1:0]       quad
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] sum;
    logic [POS_W-1:0] pos_d;
    logic [1:0]       quad_q;

    // One conditional subtract suffices because period >= WORD_W.
    always_comb begin
        sum      = pos_q + POS_W'(WORD_W);
        pos_d    = (sum >= period) ? sum - period : sum;
        at_start = (pos_q == '0) || (pos_q + POS_W'(WORD_W - 1) >= period);
    end

    // Advances position and word count once per word.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q  <= '0;
            quad_q <= '0;
        end else begin
            pos_q  <= pos_d;
            quad_q <= quad_q + 2'd1;
        end
    end

    assign pos  = pos_q;
    assign quad = quad_q;

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < period);

endmodule

// File: rtl/tpg_prog_player.sv
// Programmed pattern store and word extractor: bit i of the word is stored
// bit (pos+i) mod len, so patterns wrap inside a word.
// Assumes: WORD_W <= len <= PAT_MAX and pos < len.
module tpg_prog_player #(
    parameter int WORD_W  = 16,
    parameter int PAT_MAX = 256,
    parameter int LEN_W   = 9,
    parameter int WADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [LEN_W-1:0]   pos,
    input  logic [LEN_W-1:0]   len,
    output logic [WORD_W-1:0]  word
);

    localparam int ROWS  = PAT_MAX / WORD_W;
    localparam int IDX_W = $clog2(PAT_MAX);

    logic [WORD_W-1:0]  rows_q [ROWS];
    logic [PAT_MAX-1:0] flat;
    logic [LEN_W:0]     idx;

    // Row-wide writes into the pattern store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
        end else if (wr_en) begin
            rows_q[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign flat[g*WORD_W +: WORD_W] = rows_q[g];
    end

    // Picks each output bit with a single wrap correction.
    always_comb begin
        idx = '0;
        for (int i = 0; i < WORD_W; i++) begin
            idx = {1'b0, pos} + (LEN_W+1)'(i);
            if (idx >= {1'b0, len}) idx = idx - {1'b0, len};
            word[i] = flat[idx[IDX_W-1:0]];
        end
    end

    // R5
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rows_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/tpg_top.sv
// Word-parallel bit-error-test pattern generator: captures the configuration on
// restart, selects sequence or pattern words, adds error insertion and builds
// the trigger word. Both outputs are registered.
// Assumes: bit 0 of each word is serialized first.
module tpg_top
    import tpg_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PAT_MIN = 16,
    parameter int PAT_MAX = 256,
    parameter int LEN_W   = $clog2(PAT_MAX + 1),
    parameter int WADDR_W = $clog2(PAT_MAX / WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               prog_mode,
    input  logic [2:0]         prbs_code,
    input  logic [LEN_W-1:0]   pat_len,
    input  logic [1:0]         trig_code,
    input  logic               err_ins,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  data_word,
    output logic [WORD_W-1:0]  trig_word
);

    localparam int POS_W = 32;
    localparam logic [WORD_W-1:0] HALF_ON = {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}};

    logic             mode_q;
    logic [2:0]       code_q;
    logic [LEN_W-1:0] len_q;
    trig_mode_e       trig_q;
    logic [LEN_W-1:0] len_clamp;
    logic [POS_W-1:0] period;
    logic [POS_W-1:0] pos_w;
    logic             at_start;
    logic [1:0]       quad;
    logic [WORD_W-1:0] prbs_word;
    logic [WORD_W-1:0] prog_word;
    logic [WORD_W-1:0] gen_word;
    logic [WORD_W-1:0] trig_d;

    // Clamps the requested pattern length into the legal range.
    always_comb begin
        if (pat_len < LEN_W'(PAT_MIN))      len_clamp = LEN_W'(PAT_MIN);
        else if (pat_len > LEN_W'(PAT_MAX)) len_clamp = LEN_W'(PAT_MAX);
        else                                len_clamp = pat_len;
    end

    // Captures the configuration on restart; reset loads the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            code_q <= 3'd0;
            len_q  <= LEN_W'(PAT_MIN);
            trig_q <= TRIG_WORD;
        end else if (restart) begin
            mode_q <= prog_mode;
            code_q <= prbs_code;
            len_q  <= len_clamp;
            trig_q <= trig_mode_e'(trig_code);
        end
    end

    // Repetition period of the active source, in bits.
    always_comb begin
        if (mode_q) period = POS_W'(len_q);
        else        period = (POS_W'(1) << (6'(prbs_hi_idx(code_q)) + 6'd1)) - POS_W'(1);
    end

    tpg_prbs_core #(.WORD_W(WORD_W)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .code    (code_q),
        .word    (prbs_word)
    );

    tpg_pos #(.WORD_W(WORD_W), .POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .period   (period),
        .pos      (pos_w),
        .at_start (at_start),
        .quad     (quad)
    );

    tpg_prog_player #(
        .WORD_W (WORD_W),
        .PAT_MAX(PAT_MAX),
        .LEN_W  (LEN_W),
        .WADDR_W(WADDR_W)
    ) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pos     (pos_w[LEN_W-1:0]),
        .len     (len_q),
        .word    (prog_word)
    );

    // Selects the data source and the trigger shape.
    always_comb begin
        gen_word = mode_q ? prog_word : prbs_word;
        case (trig_q)
            TRIG_WORD: trig_d = HALF_ON;
            TRIG_QUAD: trig_d = (quad < 2'd2) ? '1 : '0;
            TRIG_PAT:  trig_d = at_start ? '1 : '0;
            default:   trig_d = '0;
        endcase
    end

    // Output registers; err_ins flips bit 0 of the word leaving this edge.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            data_word <= '0;
            trig_word <= '0;
        end else begin
            data_word <= gen_word ^ WORD_W'(err_ins);
            trig_word <= trig_d;
        end
    end

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (data_word == '0) && (trig_word == '0));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(mode_q) && $stable(code_q) && $stable(len_q) && $stable(trig_q));

    // R8
    trig_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_word == '0) || (trig_word == '1) || (trig_word == HALF_ON));

    // R5
    prog_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (pos_w < POS_W'(len_q)));

endmodule

// File: tb/tpg_top_tb.sv
module tpg_top_tb;

    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic          prog_mode = 1'b0;
    logic [2:0]    prbs_code = '0;
    logic [8:0]    pat_len = 9'd16;
    logic [1:0]    trig_code = '0;
    logic          err_ins = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] data_word;
    logic [WW-1:0] trig_word;

    int checks = 0;
    int failures = 0;
    bit seqb [0:4095];
    bit dutb [0:4095];
    int ord_t [7] = '{7, 9, 10, 11, 15, 23, 31};
    int tap_t [7] = '{6, 5, 7, 9, 14, 18, 28};

    always #4 clk = ~clk;

    tpg_top u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .prog_mode(prog_mode),
        .prbs_code(prbs_code), .pat_len(pat_len), .trig_code(trig_code),
        .err_ins(err_ins), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .data_word(data_word), .trig_word(trig_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic bit patbit(input int j);
        return ((j * 13 + j / 7) % 5) < 2;
    endfunction

    function automatic bit word_has_start(input int k, input longint per);
        longint s = (longint'(k) * 16) % per;
        return (s == 0) || (s + 15 >= per);
    endfunction

    function automatic logic [WW-1:0] exp_trig(input int tc, input int k, input longint per);
        case (tc)
            0: return 16'h00FF;
            1: return ((k % 4) < 2) ? 16'hFFFF : 16'h0000;
            2: return word_has_start(k, per) ? 16'hFFFF : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic restart_cfg(input bit pm, input int code, input int len, input int tc);
        @(negedge clk);
        prog_mode = pm; prbs_code = 3'(code); pat_len = 9'(len); trig_code = 2'(tc);
        restart = 1'b1;
        @(negedge clk);
        chk(data_word == '0 && trig_word == '0, "R7", {data_word, trig_word}, 32'h0);
        restart = 1'b0;
    endtask

    task automatic run_prbs(input int code, input int nw, input int tc, input int err_at,
                            input int poke_at, input string tag);
        int p = ord_t[code];
        int q = tap_t[code];
        bit inv = (code >= 4);
        longint per = (longint'(1) << p) - 1;
        for (int n = 0; n < 4096; n++) begin
            bit a = (n - p < 0) ? 1'b1 : seqb[n - p];
            bit b = (n - q < 0) ? 1'b1 : seqb[n - q];
            seqb[n] = a ^ b;
        end
        for (int k = 0; k < nw; k++) begin
            logic [WW-1:0] e;
            string t;
            @(negedge clk);
            for (int i = 0; i < WW; i++) e[i] = seqb[16*k + i] ^ inv;
            t = inv ? "R3" : tag;
            if (k == err_at) begin e[0] = ~e[0]; t = "R10"; end
            if (poke_at >= 0 && k > poke_at) t = "R7";
            chk(data_word == e, t, data_word, e);
            chk(trig_word == exp_trig(tc, k, per), (tc == 2) ? "R9" : "R8",
                trig_word, exp_trig(tc, k, per));
            for (int i = 0; i < WW; i++) dutb[16*k + i] = data_word[i];
            err_ins = (k + 1 == err_at);
            if (k == poke_at) begin
                prog_mode = 1'b1; prbs_code = 3'd6; pat_len = 9'd100; trig_code = 2'd3;
            end
        end
        if (code == 0 && nw * 16 > 300) begin
            bit ok = 1'b1;
            for (int n = 0; n + 127 < nw * 16; n++) if (dutb[n] != dutb[n + 127]) ok = 1'b0;
            chk(ok, "R4", 32'(ok), 32'h1);
        end
    endtask

    task automatic run_prog(input int len, input int nw, input int tc, input string tag);
        for (int k = 0; k < nw; k++) begin
            logic [WW-1:0] e;
            @(negedge clk);
            for (int i = 0; i < WW; i++) e[i] = patbit((16*k + i) % len);
            chk(data_word == e, tag, data_word, e);
            chk(trig_word == exp_trig(tc, k, longint'(len)), (tc == 2) ? "R9" : "R8",
                trig_word, exp_trig(tc, k, longint'(len)));
        end
    endtask

    task automatic write_pattern();
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(r);
            for (int i = 0; i < WW; i++) wr_data[i] = patbit(16*r + i);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (c > 0) chk(data_word == '0 && trig_word == '0, "R1", {data_word, trig_word}, 32'h0);
        end
        rst_n = 1'b1;
        run_prbs(0, 4, 0, -1, -1, "R1");
        write_pattern();
        for (int c = 0; c < 7; c++) begin
            restart_cfg(1'b0, c, 16, 2);
            run_prbs(c, (c == 0) ? 140 : 12, 2, -1, -1, "R2");
        end
        restart_cfg(1'b0, 1, 16, 1);
        run_prbs(1, 20, 1, 6, -1, "R2");
        restart_cfg(1'b0, 2, 16, 0);
        run_prbs(2, 12, 0, -1, 3, "R8");
        restart_cfg(1'b0, 3, 16, 3);
        run_prbs(3, 6, 3, -1, -1, "R8");
        restart_cfg(1'b0, 7, 16, 0);
        run_prbs(0, 6, 0, -1, -1, "R2");
        for (int len = 16; len <= 256; len++) begin
            restart_cfg(1'b1, 0, len, 2);
            run_prog(len, (2 * len) / 16 + 3, 2, "R5");
        end
        restart_cfg(1'b1, 0, 5, 1);
        run_prog(16, 8, 1, "R6");
        restart_cfg(1'b1, 0, 300, 2);
        run_prog(256, 36, 2, "R6");
        restart_cfg(1'b1, 0, 0, 0);
        run_prog(16, 4, 0, "R6");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule